// File: doc/BRIEF.md
# Delayed Lockstep Comparator

This block sits between two redundant processing units that run the same work in delayed lockstep. The primary unit runs on live inputs. The block holds those inputs in a shift register for a fixed number of cycles and then feeds them to the shadow unit. The shadow unit therefore repeats the primary's work exactly that many cycles later, and it never reaches the shared memories itself: any read data it needs arrives inside the delayed input bundle.

The primary's output bundle goes through an equal-length delay line, and so does its snapshot of monitored architectural registers. The block compares the delayed primary bundles every cycle with the shadow unit's live output and register snapshot. A difference sets a single-bit corruption flag. The flag stays high until reset, and integrator logic decides how to react to it.

The flag cannot be set while the shadow unit is held in reset, while the disable input is high, or after a debug-mode indication has been seen since the last reset. An injection input forces a trip, so the checker's own path can be tested. The shadow unit's reset asserts together with the primary reset and is released only once the delay lines have filled.

Top module: `lockstep_checker`

## Requirements
- R1: `shd_in_o` equals the value that `pri_in_i` had DELAY clock edges earlier. Until DELAY edges have passed since reset, `shd_in_o` is all zeros.
- R2: If the delayed primary output bundle differs from `shd_out_i` in any bit while checking is enabled, `corrupt_o` is high after the next clock edge.
- R3: When REG_CMP_EN is 1 (the default), a difference in any bit between the delayed primary register snapshot and `shd_reg_i` sets `corrupt_o` in the same way.
- R4: When `inject_i` is high while checking is enabled, `corrupt_o` is set even if both units agree.
- R5: `corrupt_o` cannot be set in a cycle in which `shd_rst_o` is high.
- R6: While `chk_disable_i` is high, neither a mismatch nor `inject_i` sets `corrupt_o`.
- R7: Once `dbg_mode_i` has been high on any clock edge outside reset, `corrupt_o` cannot be set until the next reset.
- R8: `shd_rst_o` is high whenever `rst_i` is high. After `rst_i` falls, `shd_rst_o` stays high for exactly DELAY clock edges and then goes low.
- R9: Once set, `corrupt_o` stays high until `rst_i` is sampled high, and reset clears it on that edge.
- R10: When the shadow unit reproduces the primary's outputs and registers, `corrupt_o` stays low.
- R11: DELAY must be 2, 3 or 4. Any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset shared with the primary unit |
| dbg_mode_i | input | 1 | Primary unit is in debug mode; locks checking off until reset |
| chk_disable_i | input | 1 | Suppresses setting of the corruption flag |
| inject_i | input | 1 | Forces a corruption trip to test the checker |
| pri_in_i | input | IN_W | Input bundle of the primary unit |
| pri_out_i | input | OUT_W | Output bundle of the primary unit |
| pri_reg_i | input | REG_W | Monitored register snapshot of the primary unit |
| shd_in_o | output | IN_W | Delayed input bundle driven to the shadow unit |
| shd_out_i | input | OUT_W | Output bundle of the shadow unit |
| shd_reg_i | input | REG_W | Monitored register snapshot of the shadow unit |
| shd_rst_o | output | 1 | Reset to the shadow unit |
| corrupt_o | output | 1 | Sticky corruption flag |

## Verification
On every cycle, assertions check the following:
- the shadow feed against the primary input from DELAY cycles earlier;
- the release point of the shadow reset;
- that the flag never drops without a reset;
- that any rising edge of the flag came after an edge where the shadow was out of reset, checking was enabled, no debug indication was present, and a mismatch or an injection was present.

Only the bench scenarios can show the other half: that a one-bit corruption at either end of the output word or in the register word actually trips the flag, that the lockout lasts across later injections until a reset clears it, and that matching units leave the flag low over a long run of varied inputs.

// File: rtl/lockstep_pkg.sv
package lockstep_pkg;

    localparam int unsigned DELAY_MIN = 2;
    localparam int unsigned DELAY_MAX = 4;

    typedef enum logic {
        CHK_LIVE   = 1'b0,
        CHK_LOCKED = 1'b1
    } chk_state_e;

    typedef struct packed {
        chk_state_e state;
        logic       flag;
    } chk_reg_t;

    function automatic logic delay_legal(input int unsigned d);
        return (d >= DELAY_MIN) && (d <= DELAY_MAX);
    endfunction

endpackage

// File: rtl/ls_delay_line.sv
module ls_delay_line #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 3
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    logic [W-1:0] stage_q [DEPTH];

    // Every stage clears on reset so the comparator never sees stale data
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[s] <= '0;
                else       stage_q[s] <= din_i;
            end
        end else begin : g_body
            always_ff @(posedge clk_i) begin
                if (rst_i) stage_q[s] <= '0;
                else       stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout_o = stage_q[DEPTH-1];

endmodule

// File: rtl/ls_shadow_reset.sv
module ls_shadow_reset #(
    parameter int unsigned DELAY = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic shd_rst_o
);

    localparam int unsigned CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] CNT_DONE = CW'(DELAY);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)                cnt_q <= '0;
        else if (cnt_q != CNT_DONE) cnt_q <= cnt_q + 1'b1;
    end

    // Enters reset with the primary; leaves once the delay lines hold real data
    assign shd_rst_o = rst_i | (cnt_q != CNT_DONE);

    // R8: release comes DELAY edges after the primary reset drops
    p_release_after_delay_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(shd_rst_o) |-> (!$past(rst_i, DELAY) && $past(rst_i, DELAY + 1)));

endmodule

// File: rtl/ls_bundle_cmp.sv
module ls_bundle_cmp #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] ref_i,
    input  logic [W-1:0] obs_i,
    output logic         diff_o
);

    assign diff_o = |(ref_i ^ obs_i);

endmodule

// File: rtl/ls_flag_ctrl.sv
module ls_flag_ctrl
    import lockstep_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic shd_rst_i,
    input  logic dbg_mode_i,
    input  logic chk_disable_i,
    input  logic inject_i,
    input  logic mismatch_i,
    output logic corrupt_o
);

    chk_reg_t q, d;
    logic     trip;

    always_comb begin
        trip = (q.state == CHK_LIVE) && !dbg_mode_i && !shd_rst_i &&
               !chk_disable_i && (mismatch_i || inject_i);
        d = q;
        if (trip)       d.flag  = 1'b1;
        if (dbg_mode_i) d.state = CHK_LOCKED;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) q <= '{state: CHK_LIVE, flag: 1'b0};
        else       q <= d;
    end

    assign corrupt_o = q.flag;

    // R7: a debug indication blocks any trip on that edge
    p_debug_blocks_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(corrupt_o) |-> !$past(dbg_mode_i));

    // R7: the lockout persists until reset
    p_lockout_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (q.state == CHK_LOCKED) |=> !$rose(corrupt_o));

endmodule

// File: rtl/lockstep_checker.sv
module lockstep_checker
    import lockstep_pkg::*;
#(
    parameter int unsigned IN_W       = 16,
    parameter int unsigned OUT_W      = 16,
    parameter int unsigned REG_W      = 32,
    parameter int unsigned DELAY      = 3,
    parameter bit          REG_CMP_EN = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             dbg_mode_i,
    input  logic             chk_disable_i,
    input  logic             inject_i,
    input  logic [IN_W-1:0]  pri_in_i,
    input  logic [OUT_W-1:0] pri_out_i,
    input  logic [REG_W-1:0] pri_reg_i,
    output logic [IN_W-1:0]  shd_in_o,
    input  logic [OUT_W-1:0] shd_out_i,
    input  logic [REG_W-1:0] shd_reg_i,
    output logic             shd_rst_o,
    output logic             corrupt_o
);

    // R11: only the supported lag values elaborate
    if (!delay_legal(DELAY)) begin : g_bad_delay
        $error("lockstep_checker: DELAY must lie between 2 and 4");
    end

    logic [OUT_W-1:0] pri_out_dly;
    logic             out_diff;
    logic             reg_diff;
    logic             any_diff;

    ls_delay_line #(.W(IN_W), .DEPTH(DELAY)) u_in_dly (
        .clk_i (clk_i), .rst_i (rst_i), .din_i (pri_in_i), .dout_o (shd_in_o)
    );

    ls_delay_line #(.W(OUT_W), .DEPTH(DELAY)) u_out_dly (
        .clk_i (clk_i), .rst_i (rst_i), .din_i (pri_out_i), .dout_o (pri_out_dly)
    );

    ls_bundle_cmp #(.W(OUT_W)) u_out_cmp (
        .ref_i (pri_out_dly), .obs_i (shd_out_i), .diff_o (out_diff)
    );

    if (REG_CMP_EN) begin : g_reg_cmp
        logic [REG_W-1:0] pri_reg_dly;

        ls_delay_line #(.W(REG_W), .DEPTH(DELAY)) u_reg_dly (
            .clk_i (clk_i), .rst_i (rst_i), .din_i (pri_reg_i), .dout_o (pri_reg_dly)
        );

        ls_bundle_cmp #(.W(REG_W)) u_reg_cmp (
            .ref_i (pri_reg_dly), .obs_i (shd_reg_i), .diff_o (reg_diff)
        );
    end else begin : g_no_reg_cmp
        assign reg_diff = 1'b0;
    end

    assign any_diff = out_diff | reg_diff;

    ls_shadow_reset #(.DELAY(DELAY)) u_shd_rst (
        .clk_i (clk_i), .rst_i (rst_i), .shd_rst_o (shd_rst_o)
    );

    ls_flag_ctrl u_flag (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .shd_rst_i     (shd_rst_o),
        .dbg_mode_i    (dbg_mode_i),
        .chk_disable_i (chk_disable_i),
        .inject_i      (inject_i),
        .mismatch_i    (any_diff),
        .corrupt_o     (corrupt_o)
    );

    // R1: once released, the shadow sees the primary input DELAY edges late
    p_shadow_feed_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        !shd_rst_o |-> (shd_in_o == $past(pri_in_i, DELAY)));

    // R2, R3, R4: the flag rises only on a mismatch or an injection
    p_trip_cause_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(corrupt_o) |-> $past(any_diff || inject_i));

    // R5: no trip while the shadow unit is held in reset
    p_gate_shadow_reset_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(corrupt_o) |-> !$past(shd_rst_o));

    // R6: the disable input suppresses trips
    p_gate_disable_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(corrupt_o) |-> !$past(chk_disable_i));

    // R9: the flag holds until reset
    p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        corrupt_o |=> corrupt_o);

    // R8: the shadow unit is in reset whenever the primary is
    p_shadow_in_reset_r8: assert property (@(posedge clk_i)
        rst_i |-> shd_rst_o);

endmodule

// File: tb/lockstep_checker_tb.sv
module lockstep_checker_tb;

    localparam int unsigned D = 3;

    typedef struct packed {
        logic [15:0] om;
        logic [31:0] rm;
        logic        inj;
        logic        dis;
        logic        exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{om: 16'h0001, rm: 32'h0,         inj: 1'b0, dis: 1'b0, exp: 1'b1, req: 4'd2},
        '{om: 16'h8000, rm: 32'h0,         inj: 1'b0, dis: 1'b0, exp: 1'b1, req: 4'd2},
        '{om: 16'h0000, rm: 32'h0001_0000, inj: 1'b0, dis: 1'b0, exp: 1'b1, req: 4'd3},
        '{om: 16'h0000, rm: 32'h8000_0000, inj: 1'b0, dis: 1'b0, exp: 1'b1, req: 4'd3},
        '{om: 16'h0000, rm: 32'h0,         inj: 1'b1, dis: 1'b0, exp: 1'b1, req: 4'd4},
        '{om: 16'h00FF, rm: 32'h0000_0F00, inj: 1'b0, dis: 1'b1, exp: 1'b0, req: 4'd6},
        '{om: 16'h0000, rm: 32'h0,         inj: 1'b1, dis: 1'b1, exp: 1'b0, req: 4'd6},
        '{om: 16'h0000, rm: 32'h0,         inj: 1'b0, dis: 1'b0, exp: 1'b0, req: 4'd10}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg = 1'b0;
    logic        dis = 1'b0;
    logic        inj = 1'b0;
    logic [15:0] pri_in = '0;
    logic [15:0] om = '0;
    logic [31:0] rm = '0;
    logic [15:0] pri_out, shd_out, shd_in;
    logic [31:0] pri_reg, shd_reg;
    logic        shd_rst, corrupt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [15:0] unit_out(input logic [15:0] x);
        return {x[7:0], x[15:8]} ^ 16'h3C0F;
    endfunction

    function automatic logic [31:0] unit_reg(input logic [15:0] x);
        return {x ^ 16'hA5C3, x + 16'd7};
    endfunction

    // Behavioural primary and shadow units; the shadow can be corrupted by masks
    assign pri_out = unit_out(pri_in);
    assign pri_reg = unit_reg(pri_in);
    assign shd_out = unit_out(shd_in) ^ om;
    assign shd_reg = unit_reg(shd_in) ^ rm;

    lockstep_checker #(.IN_W(16), .OUT_W(16), .REG_W(32), .DELAY(D), .REG_CMP_EN(1'b1)) u_dut (
        .clk_i (clk), .rst_i (rst), .dbg_mode_i (dbg), .chk_disable_i (dis),
        .inject_i (inj), .pri_in_i (pri_in), .pri_out_i (pri_out), .pri_reg_i (pri_reg),
        .shd_in_o (shd_in), .shd_out_i (shd_out), .shd_reg_i (shd_reg),
        .shd_rst_o (shd_rst), .corrupt_o (corrupt)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] hist [12];
        @(negedge clk);
        tick();

        // Reset state (R8, R9, R1)
        chk("R9 flag low in reset", 32'(corrupt), 32'd0);
        chk("R8 shadow reset high in reset", 32'(shd_rst), 32'd1);
        chk("R1 shadow feed cleared in reset", 32'(shd_in), 32'd0);

        // R8: release exactly D edges after reset drops
        rst = 1'b0;
        for (int k = 1; k <= D; k++) begin
            tick();
            chk("R8 shadow reset release", 32'(shd_rst), (k < D) ? 32'd1 : 32'd0);
        end

        // R1: delayed feed, zeros before the line fills
        do_reset();
        for (int k = 0; k < 12; k++) begin
            hist[k] = 16'h1111 * 16'(k + 1) ^ 16'h0F5A;
            pri_in  = hist[k];
            tick();
            if (k + 1 >= D) chk("R1 delayed feed", 32'(shd_in), 32'(hist[k + 1 - D]));
            else            chk("R1 zero fill",    32'(shd_in), 32'd0);
        end

        // Vector table: one corruption or control pattern per entry
        for (int v = 0; v < NV; v++) begin
            do_reset();
            repeat (D + 1) tick();
            pri_in = 16'h4E21 + 16'(v * 97);
            om  = VECS[v].om;
            rm  = VECS[v].rm;
            inj = VECS[v].inj;
            dis = VECS[v].dis;
            tick();
            om  = '0;
            rm  = '0;
            inj = 1'b0;
            dis = 1'b0;
            tick();
            tick();
            chk($sformatf("R%0d vector %0d", VECS[v].req, v), 32'(corrupt), 32'(VECS[v].exp));
        end

        // R5: corruption and injection while the shadow is still in reset
        rst = 1'b1;
        om  = 16'hFFFF;
        inj = 1'b1;
        tick();
        rst = 1'b0;
        repeat (D) tick();
        om  = '0;
        inj = 1'b0;
        tick();
        tick();
        chk("R5 no trip during shadow reset", 32'(corrupt), 32'd0);

        // R7: debug indication locks checking off
        dbg = 1'b1;
        tick();
        dbg = 1'b0;
        inj = 1'b1;
        om  = 16'h0100;
        repeat (3) tick();
        inj = 1'b0;
        om  = '0;
        tick();
        chk("R7 lockout after debug", 32'(corrupt), 32'd0);

        // R7: reset ends the lockout
        do_reset();
        repeat (D + 1) tick();
        inj = 1'b1;
        tick();
        inj = 1'b0;
        tick();
        chk("R7 lockout cleared by reset", 32'(corrupt), 32'd1);

        // R9: the flag stays high, then reset clears it
        repeat (5) tick();
        chk("R9 flag sticky", 32'(corrupt), 32'd1);
        rst = 1'b1;
        tick();
        chk("R9 reset clears flag", 32'(corrupt), 32'd0);
        rst = 1'b0;

        // R10: long agreeing run
        repeat (D + 1) tick();
        for (int k = 0; k < 200; k++) begin
            pri_in = 16'($urandom);
            tick();
        end
        chk("R10 no trip on agreement", 32'(corrupt), 32'd0);

        // R2: a later single-bit output mismatch after a long clean run
        om = 16'h0040;
        tick();
        om = '0;
        tick();
        chk("R2 late output mismatch", 32'(corrupt), 32'd1);

        finish_run();
    end

endmodule